// File: doc/BRIEF.md
# Serial Register-Access Port

This block is a slave on a three-wire serial control port. A host reaches a byte-wide register map through it using a serial clock, an active-low chip select and one data line that carries data both ways. The bidirectional line appears as separate input, output and output-enable signals for a pad to combine. Every frame opens with a 16-bit command word. The command gives the direction, the transfer length and the first register address. Data bytes follow the command. Each byte that completes on a write raises a single-cycle write strobe on a plain register-file port. On a read, the block takes the byte from that port and shifts it out.

The port pins are sampled by the system clock, and their edges are detected from those samples. A short transfer may be paused by raising chip select between bytes. Raising it partway through a byte drops the frame. A streaming transfer runs until chip select rises. One bit of a configuration register, which the block snoops at a fixed address, chooses whether bits travel most-significant first or least-significant first. The same bit sets whether the address counts down or up.

Top module: `spi_reg_slave`

## Requirements
- R1: While chip select is low, data-line bits are taken on rising serial-clock edges. The first 16 bits form the command: bit 15 = 1 for read or 0 for write, bits 14:13 = length code, bits 12:0 = first address. After reset, bits are sent most-significant first.
- R2: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. The rising edges after the last byte start a new command, even if chip select stays low.
- R3: Length code 11 moves bytes without limit until chip select rises. The next frame then begins with a new command.
- R4: On a write, each completed byte raises `reg_we` for one cycle, together with its address on `reg_addr` and its value on `reg_wdata`.
- R5: Within a frame, the address steps once per byte: down by one in most-significant-first order, up by one in least-significant-first order, wrapping modulo 2^13.
- R6: On a read, each data bit is launched on a falling serial-clock edge. The first bit goes out on the falling edge after the 16th rising edge. `sdio_oe` is high only during the data phase of a read while chip select is low.
- R7: In a 1-, 2- or 3-byte transfer, raising chip select exactly on a byte boundary keeps the frame. Once chip select is low again, the next byte continues at the next address without a new command.
- R8: Raising chip select after 1 to 7 bits of a byte, or partway through a command, abandons the frame with no write. The next bits form a new command.
- R9: Writing a byte to address `CFG_ADDR` (default 0) sets least-significant-first order when bit `CFG_LSB_BIT` (default 0) of that byte is 1, and most-significant-first order when it is 0. The new order applies to command and data bits once chip select has gone high.
- R10: After reset, `sdio_oe` and `reg_we` are low and the bit order is most-significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the port pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| csb_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Read data bit to drive onto the line |
| sdio_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 13 | Register address of the current byte |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The hardest cases to reach are a chip-select rise exactly on a byte boundary and a rise after only part of a byte. Both depend on the point in the serial-clock sequence where the host stops. The bench shifts single bits through a task, so it can raise chip select after exactly 8 or exactly 4 bits. It then checks at the write port whether the frame resumed or was dropped. The change of bit order is reached by first writing the configuration address in most-significant-first order, then running frames in the other order. Those frames include an address wrap.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int CMD_W  = 16;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(CMD_W);
    localparam int BIT_W  = $clog2(DATA_W);

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        len;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // index of the data bit that travels k-th in a byte
    function automatic logic [BIT_W-1:0] bit_sel(input logic lsb, input logic [BIT_W-1:0] k);
        return lsb ? k : BIT_W'(DATA_W - 1) - k;
    endfunction

    function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a, input logic lsb);
        return lsb ? a + 1'b1 : a - 1'b1;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic csb_n,
    input  logic sdi,
    output logic rise_ev,
    output logic fall_ev,
    output logic cs_active,
    output logic cs_rise,
    output logic sdi_bit
);
    logic sclk_q, sclk_d, csb_q, csb_d, sdi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            csb_q  <= 1'b1;
            csb_d  <= 1'b1;
            sdi_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            csb_q  <= csb_n;
            csb_d  <= csb_q;
            sdi_q  <= sdi;
        end
    end

    assign cs_active = ~csb_q;
    assign rise_ev   = sclk_q & ~sclk_d & ~csb_q;
    assign fall_ev   = ~sclk_q & sclk_d & ~csb_q;
    assign cs_rise   = csb_q & ~csb_d;
    assign sdi_bit   = sdi_q;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              lsb,
    input  logic              din,
    output logic [CMD_W-1:0]  word_nxt,
    output logic [DATA_W-1:0] byte_nxt
);
    logic [CMD_W-1:0] sr;

    always_comb begin
        if (lsb) word_nxt = {din, sr[CMD_W-1:1]};
        else     word_nxt = {sr[CMD_W-2:0], din};
    end

    assign byte_nxt = lsb ? word_nxt[CMD_W-1 -: DATA_W] : word_nxt[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)        sr <= '0;
        else if (shift) sr <= word_nxt;
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR    = '0,
    parameter int                CFG_LSB_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_ev,
    input  logic              cs_rise,
    input  logic              cs_active,
    input  logic [CMD_W-1:0]  word_nxt,
    input  logic [DATA_W-1:0] byte_nxt,
    output logic              data_phase,
    output logic              rd,
    output logic [BIT_W-1:0]  bit_pos,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              lsb
);
    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic              stream_q;
    logic [1:0]        left_q;
    logic              cfg_pend;
    cmd_t              cmd;

    assign cmd        = cmd_t'(word_nxt);
    assign data_phase = (phase == PH_DATA);
    assign bit_pos    = cnt[BIT_W-1:0];
    assign we         = rise_ev && data_phase && !rd && (cnt == CNT_W'(DATA_W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            rd       <= 1'b0;
            stream_q <= 1'b0;
            left_q   <= '0;
            addr     <= '0;
        end else if (cs_rise) begin
            if (cnt != '0 || phase == PH_CMD || stream_q) begin
                phase <= PH_CMD;
                cnt   <= '0;
            end
        end else if (rise_ev) begin
            if (phase == PH_CMD) begin
                if (cnt == CNT_W'(CMD_W-1)) begin
                    phase    <= PH_DATA;
                    cnt      <= '0;
                    rd       <= cmd.rd;
                    left_q   <= cmd.len;
                    stream_q <= (cmd.len == 2'b11);
                    addr     <= cmd.addr;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == CNT_W'(DATA_W-1)) begin
                    cnt <= '0;
                    if (stream_q || left_q != '0) begin
                        addr <= addr_step(addr, lsb);
                        if (!stream_q) left_q <= left_q - 1'b1;
                    end else begin
                        phase <= PH_CMD;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // bit-order configuration: captured on write, applied while deselected
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_pend <= 1'b0;
            lsb      <= 1'b0;
        end else begin
            if (we && addr == CFG_ADDR) cfg_pend <= byte_nxt[CFG_LSB_BIT];
            if (!cs_active)             lsb      <= cfg_pend;
        end
    end

    p_midbyte_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && cnt != '0) |=> (phase == PH_CMD && cnt == '0));

    p_stall_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && data_phase && cnt == '0 && !stream_q) |=> (data_phase && $stable(addr)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rise_ev && data_phase && cnt == CNT_W'(DATA_W-1) && (stream_q || left_q != '0))
        |=> addr == addr_step($past(addr), $past(lsb)));

    p_data_cnt_r2: assert property (@(posedge clk) disable iff (rst)
        data_phase |-> cnt < CNT_W'(DATA_W));
endmodule

// File: rtl/spi_tx_launch.sv
module spi_tx_launch
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_ev,
    input  logic              active,
    input  logic              lsb,
    input  logic [BIT_W-1:0]  bit_pos,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo
);
    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] src;

    assign src = (bit_pos == '0) ? rdata : hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            sdo  <= 1'b0;
        end else if (fall_ev && active) begin
            if (bit_pos == '0) hold <= rdata;
            sdo <= src[bit_sel(lsb, bit_pos)];
        end
    end

    p_launch_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !fall_ev |=> $stable(sdo));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR    = '0,
    parameter int                CFG_LSB_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              csb_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic rise_ev, fall_ev, cs_active, cs_rise, sdi_bit;
    logic lsb, data_phase, rd;
    logic [BIT_W-1:0]  bit_pos;
    logic [CMD_W-1:0]  word_nxt;
    logic [DATA_W-1:0] byte_nxt;

    spi_pin_sync u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .csb_n(csb_n), .sdi(sdio_in),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .cs_active(cs_active),
        .cs_rise(cs_rise), .sdi_bit(sdi_bit)
    );

    spi_rx_shift u_rx (
        .clk(clk), .rst(rst), .shift(rise_ev), .lsb(lsb), .din(sdi_bit),
        .word_nxt(word_nxt), .byte_nxt(byte_nxt)
    );

    spi_frame_ctrl #(.CFG_ADDR(CFG_ADDR), .CFG_LSB_BIT(CFG_LSB_BIT)) u_ctrl (
        .clk(clk), .rst(rst), .rise_ev(rise_ev), .cs_rise(cs_rise),
        .cs_active(cs_active), .word_nxt(word_nxt), .byte_nxt(byte_nxt),
        .data_phase(data_phase), .rd(rd), .bit_pos(bit_pos),
        .addr(reg_addr), .we(reg_we), .lsb(lsb)
    );

    spi_tx_launch u_tx (
        .clk(clk), .rst(rst), .fall_ev(fall_ev), .active(data_phase && rd),
        .lsb(lsb), .bit_pos(bit_pos), .rdata(reg_rdata), .sdo(sdio_out)
    );

    assign reg_wdata = byte_nxt;
    assign sdio_oe   = ~csb_n & data_phase & rd;

    p_we_needs_select_r4: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(!csb_n));
endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic csb_n = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, reg_we;
    logic [12:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic last_oe = 1'b0;

    logic [7:0]  mem  [0:8191];
    logic [12:0] lg_a [0:255];
    logic [7:0]  lg_d [0:255];
    int wr_cnt = 0;

    always #10 clk = ~clk;

    spi_reg_slave u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .csb_n(csb_n), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            lg_a[wr_cnt[7:0]] <= reg_addr;
            lg_d[wr_cnt[7:0]] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic chk_wr(input string r, input int idx, input int a, input int d);
        chk(r, int'(lg_a[idx[7:0]]), a);
        chk(r, int'(lg_d[idx[7:0]]), d);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic r);
        sdio_in = b;
        wait_clk(HALF);
        r = sdio_out;
        last_oe = sdio_oe;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, input logic lsb, output logic [7:0] r);
        for (int i = 0; i < 8; i++) begin
            int k;
            logic t;
            k = lsb ? i : 7 - i;
            sbit(b[k], t);
            r[k] = t;
        end
    endtask

    task automatic scmd(input logic rd, input logic [1:0] len, input logic [12:0] a, input logic lsb);
        logic [15:0] w;
        w = {rd, len, a};
        for (int i = 0; i < 16; i++) begin
            logic t;
            sbit(w[lsb ? i : 15 - i], t);
        end
    endtask

    task automatic cs_lo();
        csb_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF);
        csb_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic t_reset();
        chk("R10 oe", int'(sdio_oe), 0);
        chk("R10 we", int'(reg_we), 0);
    endtask

    task automatic t_single_write();
        int b;
        logic [7:0] r;
        b = wr_cnt;
        cs_lo(); scmd(1'b0, 2'b00, 13'h0123, 1'b0); sbyte(8'hA5, 1'b0, r); cs_hi();
        chk("R1 R4 count", wr_cnt - b, 1);
        chk_wr("R1 R4 entry", b, 'h123, 'hA5);
    endtask

    task automatic t_three_then_chain();
        int b;
        logic [7:0] r;
        b = wr_cnt;
        cs_lo();
        scmd(1'b0, 2'b10, 13'h0200, 1'b0);
        sbyte(8'h11, 1'b0, r); sbyte(8'h22, 1'b0, r); sbyte(8'h33, 1'b0, r);
        scmd(1'b0, 2'b00, 13'h0300, 1'b0);
        sbyte(8'h77, 1'b0, r);
        cs_hi();
        chk("R2 count", wr_cnt - b, 4);
        chk_wr("R5 down 0", b,     'h200, 'h11);
        chk_wr("R5 down 1", b + 1, 'h1FF, 'h22);
        chk_wr("R5 down 2", b + 2, 'h1FE, 'h33);
        chk_wr("R2 next cmd", b + 3, 'h300, 'h77);
    endtask

    task automatic t_read_two();
        logic [7:0] r;
        cs_lo(); scmd(1'b0, 2'b01, 13'h0040, 1'b0);
        sbyte(8'h3C, 1'b0, r); sbyte(8'hC3, 1'b0, r); cs_hi();
        cs_lo(); scmd(1'b1, 2'b01, 13'h0040, 1'b0);
        sbyte(8'h00, 1'b0, r);
        chk("R6 read byte0", int'(r), 'h3C);
        chk("R6 oe during read", int'(last_oe), 1);
        sbyte(8'h00, 1'b0, r);
        chk("R6 read byte1", int'(r), 'hC3);
        cs_hi();
        chk("R6 oe after deselect", int'(sdio_oe), 0);
    endtask

    task automatic t_stream();
        int b;
        logic [7:0] r;
        b = wr_cnt;
        cs_lo(); scmd(1'b0, 2'b11, 13'h0010, 1'b0);
        for (int i = 0; i < 5; i++) sbyte(8'(8'h60 + i), 1'b0, r);
        cs_hi();
        chk("R3 stream count", wr_cnt - b, 5);
        chk_wr("R3 stream last", b + 4, 'h00C, 'h64);
        cs_lo(); scmd(1'b0, 2'b00, 13'h0050, 1'b0); sbyte(8'h5A, 1'b0, r); cs_hi();
        chk_wr("R3 new frame", b + 5, 'h050, 'h5A);
    endtask

    task automatic t_stall();
        int b;
        logic [7:0] r;
        b = wr_cnt;
        cs_lo(); scmd(1'b0, 2'b10, 13'h0600, 1'b0);
        sbyte(8'hE1, 1'b0, r); cs_hi();
        cs_lo(); sbyte(8'hE2, 1'b0, r); cs_hi();
        cs_lo(); sbyte(8'hE3, 1'b0, r); cs_hi();
        chk("R7 count", wr_cnt - b, 3);
        chk_wr("R7 resume 1", b + 1, 'h5FF, 'hE2);
        chk_wr("R7 resume 2", b + 2, 'h5FE, 'hE3);
    endtask

    task automatic t_midbyte();
        int b;
        logic t;
        logic [7:0] r;
        b = wr_cnt;
        cs_lo(); scmd(1'b0, 2'b00, 13'h0700, 1'b0);
        for (int i = 0; i < 4; i++) sbit(1'b1, t);
        cs_hi();
        chk("R8 no write", wr_cnt - b, 0);
        cs_lo(); scmd(1'b0, 2'b00, 13'h0710, 1'b0); sbyte(8'h11, 1'b0, r); cs_hi();
        chk("R8 count", wr_cnt - b, 1);
        chk_wr("R8 fresh cmd", b, 'h710, 'h11);
    endtask

    task automatic t_lsb_order();
        int b;
        logic [7:0] r;
        cs_lo(); scmd(1'b0, 2'b00, 13'h0000, 1'b0); sbyte(8'h01, 1'b0, r); cs_hi();
        b = wr_cnt;
        cs_lo(); scmd(1'b0, 2'b01, 13'h0020, 1'b1);
        sbyte(8'h81, 1'b1, r); sbyte(8'h42, 1'b1, r); cs_hi();
        chk_wr("R9 lsb 0", b,     'h020, 'h81);
        chk_wr("R5 R9 up", b + 1, 'h021, 'h42);
        cs_lo(); scmd(1'b1, 2'b00, 13'h0020, 1'b1); sbyte(8'h00, 1'b1, r); cs_hi();
        chk("R6 R9 lsb read", int'(r), 'h81);
        cs_lo(); scmd(1'b0, 2'b00, 13'h0000, 1'b1); sbyte(8'h00, 1'b1, r); cs_hi();
        b = wr_cnt;
        cs_lo(); scmd(1'b0, 2'b10, 13'h0001, 1'b0);
        sbyte(8'h10, 1'b0, r); sbyte(8'h20, 1'b0, r); sbyte(8'h30, 1'b0, r); cs_hi();
        chk_wr("R9 back msb", b, 'h001, 'h10);
        chk_wr("R5 wrap", b + 2, 'h1FFF, 'h30);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_single_write();
        t_three_then_chain();
        t_read_two();
        t_stream();
        t_stall();
        t_midbyte();
        t_lsb_order();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule